// File: doc/BRIEF.md
# Minimum-Weight GF(2) Solution Search

This block takes a linear system over GF(2) that an upstream eliminator has already brought to reduced row echelon form. Each column stands for one button and each row for one light. The block returns the solution vector with the fewest ones, which is the smallest set of buttons whose combined toggling gives the target pattern. The caller supplies the reduced rows, the right-hand-side bits, the pivot column of every non-zero row, the mask of free columns and a flag that marks an inconsistent system. A single-cycle `start_i` pulse captures all of these.

Inside, the block first forms the particular solution, in which every free variable is zero and every pivot variable copies its row's right-hand bit. Next it forms one null-space basis vector for each free column. A binary counter with one bit per free variable then runs through all 2^F combinations, one per clock. For each combination the block XORs the chosen basis vectors into the particular solution, counts the ones in the result and keeps the lightest candidate seen so far. Systems are handled one after another: the outputs always describe the most recently accepted system, and they hold until the next start.

Top module: `gf2_minweight_search`

## Requirements
- R1: While reset is held, and after it is released, `busy_o`, `done_o`, `nosol_o`, `min_count_o` and `mask_o` all read zero.
- R2: For a consistent system, the reported mask satisfies every row. For each row r, the XOR over the columns c where both row r bit c (input bit `rows_i[r*NB+c]`) and mask bit c are set equals `rhs_i[r]`.
- R3: For a consistent system, `min_count_o` equals the number of ones in `mask_o`. No other solution of the system has fewer ones.
- R4: When several solutions share the minimum weight, the block reports the one reached first by the counter. Counter bit k drives the k-th free column, counted upward from column 0. A candidate replaces the current best only when its weight is strictly smaller.
- R5: With no free columns, the result is the particular solution: each pivot column holds its row's right-hand bit. It appears two cycles after the start edge.
- R6: For a consistent system with F free columns, `done_o` rises 2^F+1 clock edges after the edge that samples `start_i`, and it stays high for exactly one cycle.
- R7: When `inconsistent_i` is high at start, the block raises `done_o` one edge after the start edge, with `nosol_o` = 1, `min_count_o` = 0 and `mask_o` = 0.
- R8: A `start_i` pulse while `busy_o` is high is ignored. After `done_o`, the results hold their values until a new start is accepted.
- R9: `busy_o` is high from the first edge after an accepted start through the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Captures the system and begins a search when idle |
| rows_i | input | NL*NB | Reduced rows; row r occupies bits r*NB to r*NB+NB-1, bit c is column c |
| rhs_i | input | NL | Right-hand-side bit of each row |
| piv_col_i | input | NL*CW | Pivot column index of each row, CW bits per row |
| piv_vld_i | input | NL | Row holds a pivot |
| free_mask_i | input | NB | Columns without a pivot |
| inconsistent_i | input | 1 | System has no solution |
| busy_o | output | 1 | Search in progress or result being presented |
| done_o | output | 1 | One-cycle pulse when results are final |
| nosol_o | output | 1 | Last system had no solution |
| min_count_o | output | 8 | Fewest button presses |
| mask_o | output | NB | Buttons to press |

## Verification
The result of a consistent system is due 2^F+1 edges after the start edge, where F is the number of free columns. An inconsistent system answers after a single edge. For every case, the bench computes F from the free mask it generated and counts edges at the falling clock until `done_o` rises. It then compares that count with the expected value and reads count, mask and status only in that cycle. On the next falling edge it confirms that the done pulse has ended and that the values hold. The expected minimum and the tie-break winner come from a brute-force pass over all 2^NB button masks. That pass orders equal-weight solutions by their packed free bits.

// File: rtl/gf2s_pkg.sv
package gf2s_pkg;

  localparam int unsigned WIDE = 256;
  typedef logic [WIDE-1:0] wide_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  // number of ones in a vector
  function automatic int unsigned ones_in(input wide_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < WIDE; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

  // position of the n-th set bit (0-based); WIDE if there is none
  function automatic int unsigned nth_one(input wide_t m, input int unsigned n);
    int unsigned seen;
    int unsigned pos;
    seen = 0;
    pos  = WIDE;
    for (int i = 0; i < WIDE; i++) begin
      if (m[i] && pos == WIDE) begin
        if (seen == n) pos = i;
        seen++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/gf2s_basis.sv
module gf2s_basis
  import gf2s_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned NL = 6,
  parameter int unsigned CW = 3
) (
  input  logic [NL*NB-1:0] rows_i,
  input  logic [NL-1:0]    rhs_i,
  input  logic [NL*CW-1:0] piv_col_i,
  input  logic [NL-1:0]    piv_vld_i,
  input  logic [NB-1:0]    free_mask_i,
  output logic [NB-1:0]    part_o,
  output logic [NB*NB-1:0] basis_o
);

  // particular solution: free variables zero, pivots copy rhs
  always_comb begin
    part_o = '0;
    for (int r = 0; r < NL; r++) begin
      if (piv_vld_i[r] && int'(piv_col_i[r*CW +: CW]) < NB) begin
        part_o[piv_col_i[r*CW +: CW]] = rhs_i[r];
      end
    end
  end

  // one null-space vector per free variable, packed by free-column rank
  for (genvar k = 0; k < NB; k++) begin : g_vec
    int unsigned fcol;
    logic [NB-1:0] vec;
    always_comb begin
      fcol = nth_one(wide_t'(free_mask_i), k);
      vec  = '0;
      if (fcol < NB) begin
        vec[fcol] = 1'b1;
        for (int r = 0; r < NL; r++) begin
          if (piv_vld_i[r] && rows_i[r*NB + int'(fcol)] &&
              int'(piv_col_i[r*CW +: CW]) < NB) begin
            vec[piv_col_i[r*CW +: CW]] = 1'b1;
          end
        end
      end
    end
    assign basis_o[k*NB +: NB] = vec;
  end

endmodule

// File: rtl/gf2s_enum.sv
module gf2s_enum
  import gf2s_pkg::*;
#(
  parameter int unsigned NB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [NB-1:0]    free_mask_i,
  input  logic [NB-1:0]    part_i,
  input  logic [NB*NB-1:0] basis_i,
  output logic [NB-1:0]    cand_o,
  output logic             last_o
);

  logic [NB-1:0] sel_q;
  logic [NB:0]   lim;
  int unsigned   nfree;

  always_comb begin
    nfree = ones_in(wide_t'(free_mask_i));
    lim   = (NB+1)'(1) << nfree;
  end

  assign last_o = (({1'b0, sel_q} + (NB+1)'(1)) == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (clr_i) begin
      sel_q <= '0;
    end else if (step_i && !last_o) begin
      sel_q <= sel_q + NB'(1);
    end
  end

  always_comb begin
    cand_o = part_i;
    for (int k = 0; k < NB; k++) begin
      if (sel_q[k]) cand_o = cand_o ^ basis_i[k*NB +: NB];
    end
  end

  assert_sel_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ({1'b0, sel_q} < lim));

  assert_sel_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_o && !clr_i) |=> (sel_q == $past(sel_q) + NB'(1)));

endmodule

// File: rtl/gf2s_best.sv
module gf2s_best
  import gf2s_pkg::*;
#(
  parameter int unsigned NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          eval_i,
  input  logic [NB-1:0] cand_i,
  output logic [NB-1:0] best_mask_o,
  output logic [7:0]    best_cnt_o,
  output logic          take_o
);

  logic        have_q;
  int unsigned wt;

  always_comb wt = ones_in(wide_t'(cand_i));

  // strictly lighter wins, so the earliest of equal weight stays
  assign take_o = eval_i && (!have_q || (wt < int'(best_cnt_o)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q      <= 1'b0;
      best_cnt_o  <= '0;
      best_mask_o <= '0;
    end else if (clr_i) begin
      have_q      <= 1'b0;
      best_cnt_o  <= '0;
      best_mask_o <= '0;
    end else if (take_o) begin
      have_q      <= 1'b1;
      best_cnt_o  <= 8'(wt);
      best_mask_o <= cand_i;
    end
  end

  assert_best_never_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && have_q) |=> (best_cnt_o <= $past(best_cnt_o)));

  assert_tie_keeps_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && have_q && (wt == int'(best_cnt_o))) |=> $stable(best_mask_o));

endmodule

// File: rtl/gf2_minweight_search.sv
module gf2_minweight_search
  import gf2s_pkg::*;
#(
  parameter int unsigned NB = 8,
  parameter int unsigned NL = 6,
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NL*NB-1:0] rows_i,
  input  logic [NL-1:0]    rhs_i,
  input  logic [NL*CW-1:0] piv_col_i,
  input  logic [NL-1:0]    piv_vld_i,
  input  logic [NB-1:0]    free_mask_i,
  input  logic             inconsistent_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             nosol_o,
  output logic [7:0]       min_count_o,
  output logic [NB-1:0]    mask_o
);

  state_e state_q;

  logic [NL*NB-1:0] rows_q;
  logic [NL-1:0]    rhs_q;
  logic [NL*CW-1:0] pcol_q;
  logic [NL-1:0]    pvld_q;
  logic [NB-1:0]    free_q;
  logic             nosol_q;

  logic             start_acc;
  logic             in_run;
  logic             last_cand;
  logic             cand_take;
  logic [NB-1:0]    part;
  logic [NB*NB-1:0] basis;
  logic [NB-1:0]    cand;
  logic             sat_ok;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign in_run    = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rows_q  <= '0;
      rhs_q   <= '0;
      pcol_q  <= '0;
      pvld_q  <= '0;
      free_q  <= '0;
      nosol_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            rows_q  <= rows_i;
            rhs_q   <= rhs_i;
            pcol_q  <= piv_col_i;
            pvld_q  <= piv_vld_i;
            free_q  <= free_mask_i;
            nosol_q <= inconsistent_i;
            state_q <= inconsistent_i ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN:  if (last_cand) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  gf2s_basis #(.NB(NB), .NL(NL), .CW(CW)) u_basis (
    .rows_i      (rows_q),
    .rhs_i       (rhs_q),
    .piv_col_i   (pcol_q),
    .piv_vld_i   (pvld_q),
    .free_mask_i (free_q),
    .part_o      (part),
    .basis_o     (basis)
  );

  gf2s_enum #(.NB(NB)) u_enum (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_acc),
    .step_i      (in_run),
    .free_mask_i (free_q),
    .part_i      (part),
    .basis_i     (basis),
    .cand_o      (cand),
    .last_o      (last_cand)
  );

  gf2s_best #(.NB(NB)) u_best (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_acc),
    .eval_i      (in_run),
    .cand_i      (cand),
    .best_mask_o (mask_o),
    .best_cnt_o  (min_count_o),
    .take_o      (cand_take)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign nosol_o = nosol_q;

  // reported mask against captured rows
  always_comb begin
    sat_ok = 1'b1;
    for (int r = 0; r < NL; r++) begin
      if ((^(rows_q[r*NB +: NB] & mask_o)) != rhs_q[r]) sat_ok = 1'b0;
    end
  end

  assert_result_solves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !nosol_o) |-> sat_ok);

  assert_count_is_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !nosol_o) |-> (int'(min_count_o) == ones_in(wide_t'(mask_o))));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_nosol_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && nosol_o) |-> (min_count_o == 8'd0 && mask_o == '0));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(free_q) && $stable(rows_q) && $stable(nosol_q)));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(mask_o) && $stable(min_count_o)));

  assert_no_take_outside_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cand_take |-> busy_o);

endmodule

// File: tb/sim_gf2_minweight_search.sv
`timescale 1ns/1ps
module sim_gf2_minweight_search;

  localparam int unsigned NB = 5;
  localparam int unsigned NL = 5;
  localparam int unsigned CW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [NL*NB-1:0] rows_i = '0;
  logic [NL-1:0]    rhs_i = '0;
  logic [NL*CW-1:0] piv_col_i = '0;
  logic [NL-1:0]    piv_vld_i = '0;
  logic [NB-1:0]    free_mask_i = '0;
  logic             inconsistent_i = 1'b0;
  logic             busy_o, done_o, nosol_o;
  logic [7:0]       min_count_o;
  logic [NB-1:0]    mask_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;

  always #4 clk = ~clk;

  gf2_minweight_search #(.NB(NB), .NL(NL)) u0 (.*);

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side expectation by brute force over every button mask
  int unsigned e_cnt, e_mask, e_lat;
  bit          e_nosol;

  task automatic expect_case();
    int unsigned bw, bk, nf;
    bit found;
    bw = 999; bk = 0; found = 0; nf = 0;
    for (int c = 0; c < NB; c++) if (free_mask_i[c]) nf++;
    e_mask = 0;
    for (int x = 0; x < (1 << NB); x++) begin
      bit ok;
      int unsigned w, key, k;
      ok = 1;
      for (int r = 0; r < NL; r++) begin
        bit p;
        p = 0;
        for (int c = 0; c < NB; c++) p ^= rows_i[r*NB+c] & x[c];
        if (p != rhs_i[r]) ok = 0;
      end
      if (ok) begin
        w = 0; key = 0; k = 0;
        for (int c = 0; c < NB; c++) begin
          if (x[c]) w++;
          if (free_mask_i[c]) begin
            if (x[c]) key += (1 << k);
            k++;
          end
        end
        if (!found || w < bw || (w == bw && key < bk)) begin
          bw = w; bk = key; e_mask = x; found = 1;
        end
      end
    end
    e_nosol = !found;
    e_cnt   = found ? bw : 0;
    if (!found) e_mask = 0;
    e_lat   = found ? (1 << nf) + 1 : 1;
  endtask

  // random reduced system; bad=1 plants an impossible zero row when possible
  task automatic gen_system(input bit bad);
    int unsigned r;
    rows_i = '0; rhs_i = '0; piv_col_i = '0; piv_vld_i = '0; free_mask_i = '0;
    inconsistent_i = 1'b0;
    r = 0;
    for (int c = 0; c < NB; c++) begin
      if (r < NL && ($urandom % 2) == 1) begin
        piv_col_i[r*CW +: CW] = CW'(c);
        piv_vld_i[r] = 1'b1;
        rows_i[r*NB+c] = 1'b1;
        rhs_i[r] = 1'($urandom % 2);
        r++;
      end else begin
        free_mask_i[c] = 1'b1;
        for (int q = 0; q < NL; q++) if (q < r) rows_i[q*NB+c] = 1'($urandom % 2);
      end
    end
    if (bad && r < NL) begin
      rhs_i[r] = 1'b1;
      inconsistent_i = 1'b1;
    end
  endtask

  // start, wait, and check latency and results at the due cycle
  task automatic run_case(input string tag);
    int unsigned k;
    logic [NB-1:0] m0;
    logic [7:0]    c0;
    expect_case();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 1;
    chk({tag, " R9 busy after start"}, busy_o, 1);
    while (!done_o && k < 200) begin
      @(negedge clk);
      k++;
      if (!done_o) chk({tag, " R9 busy while searching"}, busy_o, 1);
    end
    chk({tag, " R6 latency"}, k, e_lat);
    chk({tag, " R7 nosol"}, nosol_o, e_nosol);
    chk({tag, " R3 count"}, min_count_o, e_cnt);
    chk({tag, " R2/R4 mask"}, mask_o, e_mask);
    m0 = mask_o; c0 = min_count_o;
    @(negedge clk);
    chk({tag, " R6 done pulse ends"}, done_o, 0);
    chk({tag, " R8 mask holds"}, mask_o, m0);
    chk({tag, " R8 count holds"}, min_count_o, c0);
  endtask

  initial begin
    #(8ns * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset values
    #3;
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 nosol", nosol_o, 0);
    chk("R1 count", min_count_o, 0);
    chk("R1 mask", mask_o, 0);

    // all columns free, zero target: empty press set after 33 edges
    rows_i = '0; rhs_i = '0; piv_col_i = '0; piv_vld_i = '0;
    free_mask_i = '1; inconsistent_i = 0;
    run_case("allfree");
    chk("R3 all free zero count", min_count_o, 0);

    // R5: identity, no free columns, particular solution = rhs
    rows_i = '0; piv_vld_i = '1; free_mask_i = '0; rhs_i = 5'b10110;
    for (int c = 0; c < NB; c++) begin
      rows_i[c*NB+c] = 1'b1;
      piv_col_i[c*CW +: CW] = CW'(c);
    end
    run_case("R5 identity");
    chk("R5 particular mask", mask_o, 5'b10110);

    // R4: x0 ^ x1 = 1, two weight-one answers; counter order keeps column 0
    rows_i = '0; rhs_i = '0; piv_col_i = '0; piv_vld_i = '0;
    rows_i[0] = 1'b1; rows_i[1] = 1'b1; rhs_i[0] = 1'b1; piv_vld_i[0] = 1'b1;
    free_mask_i = 5'b11110;
    run_case("R4 tie");
    chk("R4 first of equal weight", mask_o, 5'b00001);

    // R7: inconsistent flagged
    gen_system(1'b1);
    rows_i = '0; piv_vld_i = '0; piv_col_i = '0; free_mask_i = '1;
    rhs_i = '0; rhs_i[0] = 1'b1; inconsistent_i = 1'b1;
    run_case("R7 nosol");

    // R8: start during a search is ignored
    rows_i = '0; rhs_i = '0; piv_col_i = '0; piv_vld_i = '0;
    free_mask_i = '1; inconsistent_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    inconsistent_i = 1'b1; free_mask_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R8 second start ignored nosol", nosol_o, 0);
    chk("R8 second start ignored count", min_count_o, 0);
    @(negedge clk);
    chk("R8 idle after one search", busy_o, 0);

    // sweep of random reduced systems
    for (int i = 0; i < 600; i++) begin
      gen_system(($urandom % 6) == 0);
      run_case("sweep");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule